// File: doc/BRIEF.md
# Split-Boundary Memory Permission Checker

This block sits beside an on-chip SRAM window and judges every access presented to it. The lower part of the window is cut into four equal unified blocks, and each block carries its own write, read and execute permission bit. Above them lies a split region whose boundary is programmable: word offsets below the boundary take the low-range permission triple, and offsets at or above it take the high-range triple. Each access arrives as an address, a kind (read, write or instruction fetch) and a valid strobe, and in the same cycle the block answers with exactly one of allow or deny.

Two configuration registers hold the permissions. Both are loaded through a plain one-cycle write port and both are driven out at all times, so their contents can be read back. Both reset to all zeros, which means that no access inside the window is permitted. Addresses outside the window always pass, because other checkers guard other memories. A parameter can remove the unified blocks, so the same block also serves a small secondary memory. That memory has only a split region, with a narrower boundary field.

The access path is a single-cycle combinational judgement and has no ready signal: the verdict is valid whenever the strobe is high, and the block never applies back-pressure. The configuration pins are plain control signals.

Top module: `split_perm_checker`

## Requirements
- R1: After reset both configuration registers read zero, every access inside the window is denied and every access outside it is allowed.
- R2: A cycle with cfg_we high loads the unified register from cfg_wdata[3*NUM_UNI-1:0] when cfg_sel is 0, and loads the split register from cfg_wdata[BOUND_W+5:0] when cfg_sel is 1. The new value appears after that clock edge. Unused data bits are dropped, and a register keeps its value in every cycle without a write to it.
- R3: Unified block i covers byte addresses WIN_BASE + i*2^UNI_LOG2 up to the start of block i+1. Its triple is unified register bits [3i+2:3i]: bit 3i grants write, bit 3i+1 grants read and bit 3i+2 grants execute.
- R4: The split region starts right after the last unified block and spans 2^(BOUND_W+2) bytes. The boundary field is split register bits [BOUND_W-1:0] and counts 4-byte words, so the boundary is word aligned. An access whose word offset into the region is below the field uses the low triple in bits [BOUND_W+2:BOUND_W]; an access at or above the boundary uses the high triple in bits [BOUND_W+5:BOUND_W+3]. Both triples use the same W/R/X bit order as R3.
- R5: A boundary field of zero, the value stored when the boundary lies below the split region, puts the whole split region under the high triple.
- R6: acc_kind encodes 0 as read, 1 as write and 2 as fetch. An access inside the window is legal only if its kind's bit is set in the triple of the region that holds it. Kind 3 is never legal inside the window.
- R7: An access below WIN_BASE, or at or above the end of the split region, is always allowed.
- R8: While acc_valid is low, both acc_allow and acc_deny are low. While acc_valid is high, exactly one of them is high. The verdict is combinational in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the unified register, 1 the split register |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Access request strobe |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| acc_allow | output | 1 | Access is legal (qualified by acc_valid) |
| acc_deny | output | 1 | Access is illegal (qualified by acc_valid) |
| uni_cfg | output | 3*NUM_UNI | Unified-block permission register contents |
| split_cfg | output | BOUND_W+6 | Split register contents: boundary and both triples |

## Verification
The verdict is a pure function of the request and the two registers. A wrong register bit therefore shows up on acc_allow or acc_deny at the very next access that falls in the affected block or range with the affected kind. A wrong boundary compare shows up only at the words next to the boundary, so the sweep walks every half-word of the window and its edges with the boundary at zero, at its maximum and at several values in between. A register that changes without a write, or that drops a write, appears on uni_cfg or split_cfg after one clock edge.

// File: rtl/spc_pkg.sv
`timescale 1ns/1ps
package spc_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    REG_OUT  = 2'd0,
    REG_UNI  = 2'd1,
    REG_LOW  = 2'd2,
    REG_HIGH = 2'd3
  } region_e;

  localparam int TRIPLE_W = 3;
  localparam int BIT_W    = 0;
  localparam int BIT_R    = 1;
  localparam int BIT_X    = 2;

  function automatic logic kind_permitted(logic [TRIPLE_W-1:0] perm, acc_kind_e kind);
    logic ok;
    case (kind)
      ACC_READ:  ok = perm[BIT_R];
      ACC_WRITE: ok = perm[BIT_W];
      ACC_FETCH: ok = perm[BIT_X];
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/spc_cfg_regs.sv
`timescale 1ns/1ps
module spc_cfg_regs #(
  parameter int UNI_W   = 12,
  parameter int SPLIT_W = 23,
  parameter bit HAS_UNI = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic               sel,
  input  logic [31:0]        wdata,
  output logic [UNI_W-1:0]   uni_q,
  output logic [SPLIT_W-1:0] split_q
);

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata;

  generate
    if (HAS_UNI) begin : g_uni
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           uni_q <= '0;
        else if (we && !sel)  uni_q <= wdata[UNI_W-1:0];
      end

      assert_uni_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !sel) |=> (uni_q == $past(wdata[UNI_W-1:0])));

      assert_uni_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && !sel) |=> $stable(uni_q));
    end else begin : g_no_uni
      assign uni_q = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         split_q <= '0;
    else if (we && sel) split_q <= wdata[SPLIT_W-1:0];
  end

  assert_split_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel) |=> (split_q == $past(wdata[SPLIT_W-1:0])));

  assert_split_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && sel) |=> $stable(split_q));

endmodule

// File: rtl/spc_region_decode.sv
`timescale 1ns/1ps
module spc_region_decode
  import spc_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int WIN_BASE = 32'h0008_0000,
  parameter int UNI_LOG2 = 16,
  parameter int NUM_UNI  = 4,
  parameter int BOUND_W  = 17,
  parameter bit HAS_UNI  = 1'b1,
  parameter int IDX_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BOUND_W-1:0] bound,
  output region_e           region,
  output logic [IDX_W-1:0]  blk_idx
);

  localparam int UNI_SPAN   = HAS_UNI ? (NUM_UNI << UNI_LOG2) : 0;
  localparam int SPLIT_SPAN = 1 << (BOUND_W + 2);
  localparam logic [ADDR_W:0] WIN_BASE_E   = (ADDR_W+1)'(WIN_BASE);
  localparam logic [ADDR_W:0] SPLIT_BASE_E = WIN_BASE_E + (ADDR_W+1)'(UNI_SPAN);
  localparam logic [ADDR_W:0] WIN_END_E    = SPLIT_BASE_E + (ADDR_W+1)'(SPLIT_SPAN);

  logic [ADDR_W:0]  a_ext;
  logic [ADDR_W:0]  uni_off;
  logic [ADDR_W:0]  spl_off;
  logic [BOUND_W-1:0] word_off;

  always_comb begin
    a_ext    = {1'b0, addr};
    uni_off  = a_ext - WIN_BASE_E;
    spl_off  = a_ext - SPLIT_BASE_E;
    blk_idx  = IDX_W'(uni_off >> UNI_LOG2);
    word_off = BOUND_W'(spl_off >> 2);
    if (a_ext < WIN_BASE_E || a_ext >= WIN_END_E)
      region = REG_OUT;
    else if (a_ext < SPLIT_BASE_E)
      region = REG_UNI;
    else if (word_off < bound)
      region = REG_LOW;
    else
      region = REG_HIGH;
  end

  // A zero boundary leaves no low range at all.
  assert_zero_bound_no_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bound == '0) |-> (region != REG_LOW));

endmodule

// File: rtl/spc_perm_select.sv
`timescale 1ns/1ps
module spc_perm_select
  import spc_pkg::*;
#(
  parameter int NUM_UNI = 4,
  parameter int IDX_W   = 2,
  parameter int BOUND_W = 17
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  region_e                     region,
  input  logic [IDX_W-1:0]            blk_idx,
  input  acc_kind_e                   kind,
  input  logic [TRIPLE_W*NUM_UNI-1:0] uni_cfg,
  input  logic [BOUND_W+5:0]          split_cfg,
  output logic                        legal
);

  logic [TRIPLE_W-1:0] uni_perm [NUM_UNI];
  logic [TRIPLE_W-1:0] low_perm;
  logic [TRIPLE_W-1:0] high_perm;
  logic [TRIPLE_W-1:0] sel_perm;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_UNI; gi++) begin : g_blk
      assign uni_perm[gi] = uni_cfg[gi*TRIPLE_W +: TRIPLE_W];
    end
  endgenerate

  assign low_perm  = split_cfg[BOUND_W +: TRIPLE_W];
  assign high_perm = split_cfg[BOUND_W+TRIPLE_W +: TRIPLE_W];

  always_comb begin
    sel_perm = '0;
    case (region)
      REG_UNI:  sel_perm = (int'(blk_idx) < NUM_UNI) ? uni_perm[blk_idx] : '0;
      REG_LOW:  sel_perm = low_perm;
      REG_HIGH: sel_perm = high_perm;
      default:  sel_perm = '0;
    endcase
    legal = (region == REG_OUT) ? 1'b1 : kind_permitted(sel_perm, kind);
  end

  assert_outside_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (region == REG_OUT) |-> legal);

  assert_rsvd_kind_illegal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (region != REG_OUT && kind == ACC_RSVD) |-> !legal);

endmodule

// File: rtl/split_perm_checker.sv
`timescale 1ns/1ps
module split_perm_checker
  import spc_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int WIN_BASE = 32'h0008_0000,
  parameter int UNI_LOG2 = 16,
  parameter int NUM_UNI  = 4,
  parameter int BOUND_W  = 17,
  parameter bit HAS_UNI  = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic                   cfg_sel,
  input  logic [31:0]            cfg_wdata,
  input  logic                   acc_valid,
  input  logic [ADDR_W-1:0]      acc_addr,
  input  logic [1:0]             acc_kind,
  output logic                   acc_allow,
  output logic                   acc_deny,
  output logic [3*NUM_UNI-1:0]   uni_cfg,
  output logic [BOUND_W+5:0]     split_cfg
);

  localparam int UNI_W   = TRIPLE_W * NUM_UNI;
  localparam int SPLIT_W = BOUND_W + 2 * TRIPLE_W;
  localparam int IDX_W   = (NUM_UNI > 1) ? $clog2(NUM_UNI) : 1;

  region_e          region;
  logic [IDX_W-1:0] blk_idx;
  logic             legal;
  acc_kind_e        kind;

  assign kind = acc_kind_e'(acc_kind);

  spc_cfg_regs #(
    .UNI_W   (UNI_W),
    .SPLIT_W (SPLIT_W),
    .HAS_UNI (HAS_UNI)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .sel     (cfg_sel),
    .wdata   (cfg_wdata),
    .uni_q   (uni_cfg),
    .split_q (split_cfg)
  );

  spc_region_decode #(
    .ADDR_W   (ADDR_W),
    .WIN_BASE (WIN_BASE),
    .UNI_LOG2 (UNI_LOG2),
    .NUM_UNI  (NUM_UNI),
    .BOUND_W  (BOUND_W),
    .HAS_UNI  (HAS_UNI),
    .IDX_W    (IDX_W)
  ) u_decode (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (acc_addr),
    .bound   (split_cfg[BOUND_W-1:0]),
    .region  (region),
    .blk_idx (blk_idx)
  );

  spc_perm_select #(
    .NUM_UNI (NUM_UNI),
    .IDX_W   (IDX_W),
    .BOUND_W (BOUND_W)
  ) u_select (
    .clk       (clk),
    .rst_n     (rst_n),
    .region    (region),
    .blk_idx   (blk_idx),
    .kind      (kind),
    .uni_cfg   (uni_cfg),
    .split_cfg (split_cfg),
    .legal     (legal)
  );

  assign acc_allow = acc_valid &  legal;
  assign acc_deny  = acc_valid & ~legal;

  assert_one_verdict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> ($countones({acc_allow, acc_deny}) == 1));

  assert_idle_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!acc_allow && !acc_deny));

  assert_low_empty_denies_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && region == REG_LOW && split_cfg[BOUND_W +: TRIPLE_W] == '0) |-> acc_deny);

endmodule

// File: tb/split_perm_checker_bench.sv
`timescale 1ns/1ps
module split_perm_checker_bench;

  localparam int ADDR_W   = 12;
  localparam int WIN_BASE = 'h400;
  localparam int UNI_LOG2 = 6;
  localparam int NUM_UNI  = 4;
  localparam int BOUND_W  = 6;
  localparam int SPLIT_B  = WIN_BASE + (NUM_UNI << UNI_LOG2);
  localparam int WIN_END  = SPLIT_B + (1 << (BOUND_W + 2));

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic              cfg_sel = 1'b0;
  logic [31:0]       cfg_wdata = '0;
  logic              acc_valid = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [1:0]        acc_kind = '0;
  logic              acc_allow, acc_deny;
  logic [3*NUM_UNI-1:0] uni_cfg;
  logic [BOUND_W+5:0]   split_cfg;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  split_perm_checker #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .UNI_LOG2(UNI_LOG2),
    .NUM_UNI(NUM_UNI), .BOUND_W(BOUND_W), .HAS_UNI(1'b1)
  ) u_split_perm_checker (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_kind(acc_kind), .acc_allow(acc_allow), .acc_deny(acc_deny),
    .uni_cfg(uni_cfg), .split_cfg(split_cfg)
  );

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_legal(int a, int k, int uni, int spl);
    int trp, fld, w, pos;
    if (a < WIN_BASE || a >= WIN_END) return 1;
    if (a < SPLIT_B) trp = (uni >> (3 * ((a - WIN_BASE) >> UNI_LOG2))) & 7;
    else begin
      fld = spl & ((1 << BOUND_W) - 1);
      w   = (a - SPLIT_B) >> 2;
      trp = (w < fld) ? ((spl >> BOUND_W) & 7) : ((spl >> (BOUND_W + 3)) & 7);
    end
    if (k == 3) return 0;
    pos = (k == 0) ? 1 : ((k == 1) ? 0 : 2);
    return (trp >> pos) & 1;
  endfunction

  function automatic string tag_of(int a, int k, int spl);
    if (a < WIN_BASE || a >= WIN_END) return "R7";
    if (k == 3) return "R6";
    if (a < SPLIT_B) return "R3";
    if ((spl & ((1 << BOUND_W) - 1)) == 0) return "R5";
    return "R4";
  endfunction

  task automatic wr(bit sel, int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    #2;
  endtask

  task automatic probe(int a, int k, bit v, int uni, int spl, string tag);
    int e;
    @(negedge clk);
    acc_valid = v; acc_addr = ADDR_W'(a); acc_kind = 2'(k);
    #2;
    e = exp_legal(a, k, uni, spl);
    if (v) chk(tag, {30'd0, acc_allow, acc_deny}, e ? 2 : 1, $sformatf("verdict a=%0h k=%0d", a, k));
    else   chk("R8", {30'd0, acc_allow, acc_deny}, 0, $sformatf("idle a=%0h", a));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int uni, spl, fld, n;
    repeat (3) @(negedge clk);
    chk("R1", int'(uni_cfg), 0, "uni reset");
    chk("R1", int'(split_cfg), 0, "split reset");
    rst_n = 1'b1;
    probe('h410, 0, 1'b1, 0, 0, "R1");
    probe('h520, 2, 1'b1, 0, 0, "R1");
    probe('h100, 1, 1'b1, 0, 0, "R1");
    probe('h410, 0, 1'b0, 0, 0, "R8");

    wr(1'b0, 32'hFFFF_FFFF);
    chk("R2", int'(uni_cfg), 'hFFF, "uni masked load");
    wr(1'b1, 32'hFFFF_FFFF);
    chk("R2", int'(split_cfg), 'hFFF, "split masked load");
    @(negedge clk); cfg_we = 1'b0; cfg_sel = 1'b1; cfg_wdata = 0;
    @(negedge clk); #2;
    chk("R2", int'(split_cfg), 'hFFF, "split hold without write");
    wr(1'b1, 32'h0000_0ABC);
    chk("R2", int'(uni_cfg), 'hFFF, "uni untouched by split write");

    n = 0;
    for (int c = 0; c < 8; c++) begin
      uni = (c * 1443 + 455) & 'hFFF;
      if (c == 0) fld = 0;
      else if (c == 7) fld = (1 << BOUND_W) - 1;
      else fld = (c * 23 + 1) % (1 << BOUND_W);
      spl = fld | (((c * 5 + 3) & 7) << BOUND_W) | (((c * 3 + 6) & 7) << (BOUND_W + 3));
      wr(1'b0, uni);
      wr(1'b1, spl);
      chk("R2", int'(uni_cfg), uni, "uni readback");
      chk("R2", int'(split_cfg), spl, "split readback");
      for (int a = WIN_BASE - 8; a < WIN_END + 8; a += 2) begin
        for (int k = 0; k < 4; k++) begin
          n++;
          probe(a, k, (n % 7) != 0, uni, spl, tag_of(a, k, spl));
        end
      end
    end
    acc_valid = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule